// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is a management-bus master that reaches PHY registers over a two-wire serial link. It drives a management clock obtained by dividing the system clock, and it drives a shared data line through a separate output enable so that the line can be tri-stated. A single register file, reached over a plain address/write/read-data bus, selects between the older 22-style frames and the extended 45-style frames. It holds the operation to launch, the outgoing data word and the incoming data word.

Software first sets the mode and the preamble option. It then loads the write-data register when a frame needs data or an extended register address. Writing the command register starts exactly one frame. Software polls the busy flag in the data register that matches the operation. After a read it checks the good-data flag before using the returned word.

Register map, by word address on `reg_addr`: 0 is configuration, 1 is command, 2 is write data, 3 is read data. Reading the command register returns zero.

Top module: `mdio_master`

## Requirements
- R1: After reset the data line is released (`mdio_oe` = 0), `mdc` is low, both pending flags read 0, and the configuration register reads 0x2 (bit 0 frame mode = 0 for 22-style, bit 1 preamble enable = 1).
- R2: While a frame runs, `mdc` has a period of `CLK_DIV` system clocks. It is low for the first half and high for the second half of each bit. `mdio_o` changes only where `mdc` is low, and `mdio_i` is sampled where `mdc` rises.
- R3: In 22-style mode, command op code 0 (command bits [17:16]) sends a write frame: start 01, wire opcode 01, the PHY address from bits [12:8], the register address from bits [4:0], turnaround 10, then the 16-bit data from write-data bits [15:0]. All bits go MSB first with the line driven throughout.
- R4: In 22-style mode, op code 1 sends start 01 and wire opcode 10 followed by both addresses. The master then releases the line for both turnaround bits and all 16 data bits. It shifts in the 16 data bits MSB first, places them in read-data bits [15:0] and sets the valid flag (read-data bit 30).
- R5: The valid flag reads 0 after a read frame in which the PHY left the second turnaround bit high.
- R6: In 45-style mode (configuration bit 0 = 1), op code 0 sends an address frame. It has start 00, wire opcode 00, the PHY address, the device address from command bits [4:0], turnaround 10, and the 16-bit value in write-data bits [15:0] as the register address.
- R7: In 45-style mode, op code 1 sends a write frame with wire opcode 01 and the write data. Op code 3 sends a read frame with wire opcode 11 whose data is captured as in R4.
- R8: With preamble enabled each frame begins with 32 ones (64 bits in total). With it disabled the frame starts directly with the start bits (32 bits in total).
- R9: Write-data bit 31 (write pending) is set from the launch of a write or address frame until its last bit ends. Read-data bit 31 (read pending) does the same for read frames. The two are never set together.
- R10: A command write while either pending flag is set is ignored: the running frame goes out unchanged and no second frame follows.
- R11: Unsupported op codes (2 or 3 in 22-style mode, 2 in 45-style mode) start no frame and set no pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with `CLK_DIV` = 4. A full 64-bit frame with preamble therefore lasts 256 system clocks, which lets every frame type, both preamble lengths and both clause modes run in one short session. With the small divider, the half-period of `mdc` is two clocks. The exact placement of the rising and falling edges, and of the sample point against the change point, can then be measured directly. The bench plays the PHY, driving the turnaround and data bits on each falling `mdc` edge, so that both good and bad turnarounds are produced.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic          mode, pre;
  logic [15:0]   wdat, rdat, rsh;
  logic          valid, wr_pend, rd_pend, rd_op, ta_bad;
  logic [63:0]   frame;
  logic [5:0]    bidx;
  logic [CW-1:0] cnt;
  logic          mdc_r;

  logic [1:0] cmd_op;
  logic [4:0] cmd_phy, cmd_reg;
  logic [1:0] wire_op;
  logic       op_ok, is_rd, busy, launch, end_now, cmd_wr;

  assign cmd_op  = reg_wdata[17:16];
  assign cmd_phy = reg_wdata[12:8];
  assign cmd_reg = reg_wdata[4:0];
  assign busy    = wr_pend | rd_pend;
  assign cmd_wr  = reg_we && (reg_addr == 2'd1);

  always_comb begin
    wire_op = 2'b00;
    op_ok   = 1'b1;
    is_rd   = 1'b0;
    if (mode) begin
      case (cmd_op)
        2'd0: wire_op = 2'b00;
        2'd1: wire_op = 2'b01;
        2'd3: begin wire_op = 2'b11; is_rd = 1'b1; end
        default: op_ok = 1'b0;
      endcase
    end else begin
      case (cmd_op)
        2'd0: wire_op = 2'b01;
        2'd1: begin wire_op = 2'b10; is_rd = 1'b1; end
        default: op_ok = 1'b0;
      endcase
    end
  end

  assign launch  = cmd_wr && !busy && op_ok;
  assign end_now = busy && (cnt == CW'(CLK_DIV - 1)) && (bidx == 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= 1'b0;
      pre     <= 1'b1;
      wdat    <= '0;
      rdat    <= '0;
      rsh     <= '0;
      valid   <= 1'b0;
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      rd_op   <= 1'b0;
      ta_bad  <= 1'b0;
      frame   <= '0;
      bidx    <= '0;
      cnt     <= '0;
      mdc_r   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 2'd0) begin
        mode <= reg_wdata[0];
        pre  <= reg_wdata[1];
      end
      if (reg_we && reg_addr == 2'd2) wdat <= reg_wdata[15:0];
      if (launch) begin
        frame   <= {32'hFFFF_FFFF, (mode ? 2'b00 : 2'b01), wire_op,
                    cmd_phy, cmd_reg, 2'b10, wdat};
        bidx    <= pre ? 6'd63 : 6'd31;
        cnt     <= '0;
        mdc_r   <= 1'b0;
        rd_op   <= is_rd;
        ta_bad  <= 1'b0;
        wr_pend <= !is_rd;
        rd_pend <= is_rd;
        if (is_rd) valid <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(HALF - 1)) begin
          mdc_r <= 1'b1;
          if (rd_op && bidx == 6'd16) ta_bad <= mdio_i;
          if (rd_op && bidx < 6'd16) rsh <= {rsh[14:0], mdio_i};
        end
        if (cnt == CW'(CLK_DIV - 1)) begin
          cnt   <= '0;
          mdc_r <= 1'b0;
          if (bidx == 6'd0) begin
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
            if (rd_op) begin
              rdat  <= rsh;
              valid <= !ta_bad;
            end
          end else begin
            bidx <= bidx - 6'd1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign mdc     = mdc_r;
  assign mdio_o  = busy ? frame[bidx] : 1'b1;
  assign mdio_oe = busy && !(rd_op && bidx <= 6'd17);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, pre, mode};
      2'd2:    reg_rdata = {wr_pend, 15'd0, wdat};
      2'd3:    reg_rdata = {rd_pend, valid, 14'd0, rdat};
      default: reg_rdata = 32'd0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:18], reg_wdata[15:13], reg_wdata[7:5]};

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  assert_stable_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  assert_release_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && bidx <= 6'd17) |-> !mdio_oe);

  assert_single_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pend && rd_pend));

  assert_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !end_now) |=> (busy && $stable(frame)));

  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !op_ok) |=> !busy);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV = 4;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int pos = -1;
  int rises = 0;
  logic [63:0] cap, coe, phy_drv;

  mdio_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(PER/2) clk = ~clk;

  assign mdio_i = (pos >= 0 && pos < 64) ? phy_drv[pos] : 1'b1;

  always @(posedge mdc) begin
    rises = rises + 1;
    if (pos >= 0 && pos < 64) begin
      cap[pos] = mdio_o;
      coe[pos] = mdio_oe;
    end
  end
  always @(negedge mdc) pos = pos - 1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
    return {14'd0, op, 3'd0, phy, 3'd0, rg};
  endfunction

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, d};
  endfunction

  task automatic launch(input int len, input logic [31:0] c, input logic [63:0] drv);
    cap = '0; coe = '0; phy_drv = drv; pos = len - 1;
    wr(2'd1, c);
  endtask

  task automatic wait_idle;
    logic [31:0] a, b;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd2, a); rd(2'd3, b);
      if (!a[31] && !b[31]) break;
    end
  endtask

  task automatic check_frame(input int len, input logic [63:0] exp, input logic is_read, input string req);
    logic [63:0] m, mh;
    m  = (len == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
    mh = is_read ? (m & ~64'h3FFFF) : m;
    chk((cap & mh) == (exp & mh), req, cap & mh, exp & mh);
    chk((coe & m) == mh, {req, " output enable"}, coe & m, mh);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk(v == 32'h2, "R1 config reset", v, 32'h2);
    rd(2'd2, v); chk(v[31] == 1'b0, "R1 write pending reset", v, 0);
    rd(2'd3, v); chk(v[31] == 1'b0, "R1 read pending reset", v, 0);
    chk({mdc, mdio_oe} == 2'b00, "R1 line idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_c22_write;
    logic [31:0] a, b;
    wr(2'd2, 32'h0000_1234);
    launch(64, cmd(2'd0, 5'd3, 5'd4), '1);
    rd(2'd2, a); rd(2'd3, b);
    chk(a[31] && !b[31], "R9 write pending set", {a[31], b[31]}, 2'b10);
    wait_idle();
    check_frame(64, fr(2'b01, 2'b01, 5'd3, 5'd4, 16'h1234), 1'b0, "R3 R8 c22 write frame");
    rd(2'd2, a); chk(!a[31], "R9 write pending cleared", a, 0);
  endtask

  task automatic t_c22_read(input logic bad_ta);
    logic [31:0] a, b;
    logic [63:0] drv;
    drv = '1; drv[15:0] = 16'hA5C3; drv[16] = bad_ta;
    launch(64, cmd(2'd1, 5'd17, 5'd9), drv);
    rd(2'd2, a); rd(2'd3, b);
    chk(!a[31] && b[31], "R9 read pending set", {a[31], b[31]}, 2'b01);
    wait_idle();
    rd(2'd3, b);
    if (!bad_ta) begin
      check_frame(64, fr(2'b01, 2'b10, 5'd17, 5'd9, 16'h0), 1'b1, "R4 c22 read frame");
      chk(b == 32'h4000_A5C3, "R4 read data valid", b, 32'h4000_A5C3);
    end else begin
      chk(b[30] == 1'b0, "R5 valid cleared on bad turnaround", b, 0);
    end
  endtask

  task automatic t_c45;
    logic [31:0] b;
    logic [63:0] drv;
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h0000_BEEF);
    launch(32, cmd(2'd0, 5'd5, 5'd7), '1);
    wait_idle();
    check_frame(32, fr(2'b00, 2'b00, 5'd5, 5'd7, 16'hBEEF), 1'b0, "R6 R8 c45 address frame");
    wr(2'd2, 32'h0000_0F0F);
    launch(32, cmd(2'd1, 5'd5, 5'd7), '1);
    wait_idle();
    check_frame(32, fr(2'b00, 2'b01, 5'd5, 5'd7, 16'h0F0F), 1'b0, "R7 c45 write frame");
    drv = '1; drv[15:0] = 16'h3C96; drv[16] = 1'b0;
    launch(32, cmd(2'd3, 5'd30, 5'd1), drv);
    wait_idle();
    check_frame(32, fr(2'b00, 2'b11, 5'd30, 5'd1, 16'h0), 1'b1, "R7 c45 read frame");
    rd(2'd3, b);
    chk(b == 32'h4000_3C96, "R7 c45 read data", b, 32'h4000_3C96);
  endtask

  task automatic t_timing;
    realtime t0, t1, t2;
    wr(2'd0, 32'h2);
    launch(64, cmd(2'd0, 5'd1, 5'd1), '1);
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    chk((t2 - t0) == DIV * PER, "R2 mdc period", 64'(int'(t2 - t0)), 64'(DIV * PER));
    chk((t1 - t0) == (DIV / 2) * PER, "R2 mdc high time", 64'(int'(t1 - t0)), 64'((DIV / 2) * PER));
    wait_idle();
  endtask

  task automatic t_busy_ignore;
    int r0;
    wr(2'd2, 32'h0000_55AA);
    launch(64, cmd(2'd0, 5'd2, 5'd6), '1);
    repeat (40) @(negedge clk);
    wr(2'd1, cmd(2'd1, 5'd31, 5'd31));
    wait_idle();
    check_frame(64, fr(2'b01, 2'b01, 5'd2, 5'd6, 16'h55AA), 1'b0, "R10 running frame unchanged");
    r0 = rises;
    repeat (60) @(negedge clk);
    chk(rises == r0, "R10 no second frame", 64'(rises), 64'(r0));
  endtask

  task automatic t_bad_op;
    logic [31:0] a, b;
    int r0;
    r0 = rises;
    wr(2'd1, cmd(2'd2, 5'd1, 5'd1));
    rd(2'd2, a); rd(2'd3, b);
    chk(!a[31] && !b[31], "R11 c22 op2 no pending", {a[31], b[31]}, 0);
    wr(2'd1, cmd(2'd3, 5'd1, 5'd1));
    wr(2'd0, 32'h3);
    wr(2'd1, cmd(2'd2, 5'd1, 5'd1));
    rd(2'd2, a); rd(2'd3, b);
    chk(!a[31] && !b[31], "R11 c45 op2 no pending", {a[31], b[31]}, 0);
    repeat (40) @(negedge clk);
    chk(rises == r0, "R11 no mdc activity", 64'(rises), 64'(r0));
  endtask

  initial begin
    #(PER * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c22_read(1'b0);
    t_c22_read(1'b1);
    t_timing();
    t_busy_ignore();
    t_bad_op();
    t_c45();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule